// File: doc/BRIEF.md
# I2C SCL High/Low Period Generator

This block produces the serial clock for an I2C master running in standard or fast mode. It drives SCL as an open-drain line: `scl_oe` high pulls the wire low, and `scl_oe` low lets the pull-up take it high. Each mode has its own pair of programmable counts, one for the low half of the clock and one for the high half. A two-bit speed field chooses which pair is used.

The low half is timed from the cycle in which the block pulls the line down. The high half is timed only once the synchronized SCL input is seen high. A target that holds SCL low therefore stretches the clock, and the fixed synchronizer and detection cycles are part of the high-phase budget. One-cycle ticks at each falling and each observed rising edge pace an external bit engine.

The counts and the speed field are captured only while the generator is disabled. Changes made while it is running are ignored until the next enable. START/STOP sequencing and data shifting belong elsewhere.

Top module: `scl_period_gen`

## Requirements
- R1: After reset and whenever `enable` is low, `scl_oe`, `fall_tick` and `rise_tick` are 0. A low `enable` takes effect in the cycle after it is sampled.
- R2: Each low phase keeps `scl_oe` at 1 for exactly low count + 1 clock cycles, counted from the cycle in which `scl_oe` first goes to 1.
- R3: When the line rises as soon as it is released, each high phase keeps `scl_oe` at 0 for exactly high count + 8 cycles. This also holds for a high count of 0.
- R4: `speed_sel` value 1 selects the standard-mode counts and value 2 selects the fast-mode counts. The values 0 and 3 select the standard-mode counts.
- R5: If the line stays low for S extra cycles after release, the high phase lasts exactly high count + 8 + S cycles.
- R6: `fall_tick` is 1 for exactly the one cycle in which `scl_oe` goes from 0 to 1, and it is 0 at all other times.
- R7: `rise_tick` is 1 for one cycle per high phase, in the (SYNC_STAGES+2)-th cycle after release. With the default of 2 stages this is the 4th cycle; with a stretch of S cycles it is the (4+S)-th cycle. `fall_tick` and `rise_tick` are never 1 in the same cycle.
- R8: Changes to the counts or to `speed_sel` made while `enable` is high do not alter the waveform until the generator has been disabled and enabled again.
- R9: Dropping `enable` in the middle of a low phase releases the line on the next cycle. The next enable begins a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator; low releases SCL and re-arms the counts |
| speed_sel | input | 2 | Mode field: 1 selects standard, 2 selects fast |
| std_hcnt | input | CW | Standard-mode high count |
| std_lcnt | input | CW | Standard-mode low count |
| fast_hcnt | input | CW | Fast-mode high count |
| fast_lcnt | input | CW | Fast-mode low count |
| scl_in | input | 1 | Sampled level of the SCL wire |
| scl_oe | output | 1 | 1 pulls SCL low; 0 releases it |
| fall_tick | output | 1 | One-cycle pulse when SCL is pulled low |
| rise_tick | output | 1 | One-cycle pulse when SCL is seen high again |

## Verification
A target's stretch can land in the very cycle the generator releases SCL. The bench's target model raises its hold in that release cycle, keeps it for a chosen number of cycles, and then checks that the high phase and the rise tick both move by exactly that number, with no early rise caused by stale synchronizer contents. A second coincidence is a disable that arrives while a low phase is still counting. The bench drops `enable` mid-phase, checks that the line is free on the next cycle, and checks that the following enable starts a fresh low phase of full length.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

  localparam logic [1:0] SPEED_STD  = 2'd1;
  localparam logic [1:0] SPEED_FAST = 2'd2;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
  import scl_gen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [1:0]    speed_sel,
  input  logic [CW-1:0] std_hcnt,
  input  logic [CW-1:0] std_lcnt,
  input  logic [CW-1:0] fast_hcnt,
  input  logic [CW-1:0] fast_lcnt,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] lcnt
);
  logic pick_fast;
  assign pick_fast = (speed_sel == SPEED_FAST);

  // Counts are frozen for the whole run; only an idle generator reloads them.
  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      lcnt <= '0;
    end else if (load) begin
      hcnt <= pick_fast ? fast_hcnt : std_hcnt;
      lcnt <= pick_fast ? fast_lcnt : std_lcnt;
    end
  end
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int CW            = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int HIGH_OVERHEAD = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          scl_hi,
  input  logic [CW-1:0] hcnt,
  input  logic [CW-1:0] lcnt,
  output logic          cfg_load,
  output logic          scl_oe,
  output logic          fall_tick,
  output logic          rise_tick
);
  // Cycles of the high phase already spent in release, synchronizer and detection.
  localparam int HI_EXTRA = HIGH_OVERHEAD - 2 - SYNC_STAGES;
  localparam int XW       = CW + 1;

  phase_t         phase;
  logic [XW-1:0]  cnt;
  logic [XW-1:0]  lo_term;
  logic [XW-1:0]  hi_term;

  assign lo_term  = {1'b0, lcnt};
  assign hi_term  = {1'b0, hcnt} + XW'(HI_EXTRA);
  assign cfg_load = (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      scl_oe    <= 1'b0;
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
    end else begin
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
      if (!enable) begin
        phase  <= PH_IDLE;
        cnt    <= '0;
        scl_oe <= 1'b0;
      end else begin
        unique case (phase)
          PH_IDLE: begin
            phase     <= PH_LOW;
            cnt       <= '0;
            scl_oe    <= 1'b1;
            fall_tick <= 1'b1;
          end
          PH_LOW: begin
            if (cnt == lo_term) begin
              phase  <= PH_WAIT;
              cnt    <= '0;
              scl_oe <= 1'b0;
            end else begin
              cnt <= cnt + XW'(1);
            end
          end
          PH_WAIT: begin
            if (scl_hi) begin
              phase     <= PH_HIGH;
              cnt       <= '0;
              rise_tick <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (cnt == hi_term) begin
              phase     <= PH_LOW;
              cnt       <= '0;
              scl_oe    <= 1'b1;
              fall_tick <= 1'b1;
            end else begin
              cnt <= cnt + XW'(1);
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assert_off_releases_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!scl_oe && !fall_tick && !rise_tick));

  assert_low_within_count_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOW) |-> (cnt <= lo_term));

  assert_fall_marks_pull_R6: assert property (@(posedge clk) disable iff (rst)
    fall_tick |-> (scl_oe && !$past(scl_oe)));

  assert_rise_needs_line_R7: assert property (@(posedge clk) disable iff (rst)
    rise_tick |-> (!scl_oe && $past(scl_hi)));

  assert_ticks_apart_R7: assert property (@(posedge clk) disable iff (rst)
    !(fall_tick && rise_tick));
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int CW            = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int HIGH_OVERHEAD = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [1:0]    speed_sel,
  input  logic [CW-1:0] std_hcnt,
  input  logic [CW-1:0] std_lcnt,
  input  logic [CW-1:0] fast_hcnt,
  input  logic [CW-1:0] fast_lcnt,
  input  logic          scl_in,
  output logic          scl_oe,
  output logic          fall_tick,
  output logic          rise_tick
);
  logic          scl_hi;
  logic          cfg_load;
  logic [CW-1:0] act_hcnt;
  logic [CW-1:0] act_lcnt;

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (scl_in),
    .q   (scl_hi)
  );

  scl_cfg_latch #(.CW(CW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .load      (cfg_load),
    .speed_sel (speed_sel),
    .std_hcnt  (std_hcnt),
    .std_lcnt  (std_lcnt),
    .fast_hcnt (fast_hcnt),
    .fast_lcnt (fast_lcnt),
    .hcnt      (act_hcnt),
    .lcnt      (act_lcnt)
  );

  scl_phase_ctrl #(
    .CW            (CW),
    .SYNC_STAGES   (SYNC_STAGES),
    .HIGH_OVERHEAD (HIGH_OVERHEAD)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .scl_hi    (scl_hi),
    .hcnt      (act_hcnt),
    .lcnt      (act_lcnt),
    .cfg_load  (cfg_load),
    .scl_oe    (scl_oe),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick)
  );
endmodule

// File: tb/scl_period_gen_bench.sv
module scl_period_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [1:0]    speed_sel = 2'd1;
  logic [CW-1:0] std_hcnt = 16'd5, std_lcnt = 16'd7;
  logic [CW-1:0] fast_hcnt = 16'd2, fast_lcnt = 16'd3;
  logic          hold = 1'b0;
  logic          scl_in;
  logic          scl_oe, fall_tick, rise_tick;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Open-drain wire with pull-up; a stretching target adds a hold.
  assign scl_in = ~scl_oe & ~hold;

  scl_period_gen #(.CW(CW)) u_scl_period_gen (
    .clk(clk), .rst(rst), .enable(enable), .speed_sel(speed_sel),
    .std_hcnt(std_hcnt), .std_lcnt(std_lcnt),
    .fast_hcnt(fast_hcnt), .fast_lcnt(fast_lcnt),
    .scl_in(scl_in), .scl_oe(scl_oe), .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  typedef struct { int low; int high; int rise; string tag; } exp_t;
  exp_t expq[$];

  int checks = 0, errors = 0;
  bit mon_en = 0;
  int stretch_amt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  // Target model: holds the line low for stretch_amt cycles after each release.
  int  hold_left = 0;
  bit  slave_prev = 0;
  always @(negedge clk) begin
    if (!scl_oe && slave_prev && stretch_amt > 0) begin
      hold = 1'b1;
      hold_left = stretch_amt;
    end else if (hold) begin
      hold_left--;
      if (hold_left == 0) hold = 1'b0;
    end
    slave_prev = scl_oe;
  end

  // Monitor: measures phase lengths and tick positions, compares with the queue.
  bit prev = 0, had_low = 0, rise_seen = 0;
  int run = 0;
  always @(negedge clk) begin
    if (!mon_en) begin
      run = 0; had_low = 0; rise_seen = 0;
    end else begin
      if (scl_oe && !prev) check(fall_tick == 1'b1, "R6 fall tick at pull", int'(fall_tick), 1);
      else if (fall_tick) check(1'b0, "R6 stray fall tick", 1, 0);
      if (scl_oe != prev) begin
        if (prev) begin
          if (expq.size() > 0)
            check(run == expq[0].low, {expq[0].tag, " low length"}, run, expq[0].low);
          had_low = 1; rise_seen = 0;
        end else if (had_low && expq.size() > 0) begin
          check(run == expq[0].high, {expq[0].tag, " high length"}, run, expq[0].high);
          check(rise_seen, "R7 rise tick present", int'(rise_seen), 1);
          void'(expq.pop_front());
        end
        run = 1;
      end else begin
        run++;
      end
      if (rise_tick) begin
        if (expq.size() > 0)
          check(!scl_oe && run == expq[0].rise, {"R7 rise tick pos ", expq[0].tag}, run, expq[0].rise);
        rise_seen = 1;
      end
    end
    prev = scl_oe;
  end

  task automatic push(input int n, input int lo, input int hi, input int rs, input string tag);
    for (int i = 0; i < n; i++) expq.push_back('{lo, hi, rs, tag});
  endtask

  task automatic drain();
    while (expq.size() != 0) tick();
  endtask

  task automatic stop_gen();
    mon_en = 0;
    enable = 1'b0;
    tick(); tick();
    check(scl_oe == 1'b0 && !fall_tick && !rise_tick, "R1 idle after disable", int'(scl_oe), 0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1-run actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(!scl_oe && !fall_tick && !rise_tick, "R1 reset state", int'(scl_oe), 0);
    end

    // R2/R3 standard mode: low 7+1, high 5+8
    speed_sel = 2'd1; mon_en = 1;
    push(3, 8, 13, 4, "R2 R3 std");
    enable = 1'b1; drain(); stop_gen();

    // R4 fast mode
    speed_sel = 2'd2; mon_en = 1;
    push(3, 4, 10, 4, "R4 fast");
    enable = 1'b1; drain(); stop_gen();

    // R4 other field value picks standard
    speed_sel = 2'd3; mon_en = 1;
    push(2, 8, 13, 4, "R4 value3 std");
    enable = 1'b1; drain(); stop_gen();

    // R3 zero high count boundary
    speed_sel = 2'd2; fast_hcnt = 16'd0; fast_lcnt = 16'd1; mon_en = 1;
    push(2, 2, 8, 4, "R3 zero hcnt");
    enable = 1'b1; drain(); stop_gen();
    fast_hcnt = 16'd2; fast_lcnt = 16'd3;

    // R5 stretching by 5
    stretch_amt = 5; mon_en = 1;
    push(2, 4, 15, 9, "R5 stretch");
    enable = 1'b1; drain();
    stretch_amt = 0; stop_gen();

    // R8 config changes while running are ignored
    speed_sel = 2'd1; mon_en = 1;
    push(2, 8, 13, 4, "R8 frozen cfg");
    enable = 1'b1; tick();
    std_hcnt = 16'd20; std_lcnt = 16'd30; speed_sel = 2'd2;
    drain(); stop_gen();
    std_hcnt = 16'd5; std_lcnt = 16'd7;

    // R9 disable mid low phase, then full restart
    speed_sel = 2'd2; enable = 1'b1;
    tick(); tick();
    check(scl_oe == 1'b1, "R9 mid low before disable", int'(scl_oe), 1);
    enable = 1'b0; tick();
    check(scl_oe == 1'b0, "R9 release after disable", int'(scl_oe), 0);
    tick();
    mon_en = 1;
    push(1, 4, 10, 4, "R9 restart");
    enable = 1'b1; drain(); stop_gen();

    summary();
    $finish;
  end
endmodule